// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Model

This block is a synthesizable model of a three-wire serial EEPROM that holds 512 words of 16 bits in a register array. A host drives chip select, a serial clock and a serial data line. The block oversamples these pins on its own system clock and decodes a framed command. It answers on a data-out line that comes with a separate output-enable. Reads return words MSB first and keep going through the array for as long as the serial clock runs. Programming commands change the array when chip select falls. They then hold the device in a busy window whose length is counted in system clocks.

While the array is being programmed, the host can raise chip select to poll the data-out line. A low level means busy and a high level means ready. The ready level stays up until the next start bit, which puts data-out back into high impedance. Any serial activity during the busy window is ignored.

Top module: `mw_eeprom`

## Requirements
- R1: After reset every word of the array reads back as FFFFh.
- R2: While chip select is low, do_oe_o is 0, and serial clock or data activity causes no command.
- R3: Serial clock rising edges that sample data-in low before the start bit are ignored. The first rising edge that samples data-in high after chip select rises is the start bit.
- R4: A frame is: start bit, a two-bit opcode, one don't-care bit, then nine address bits, MSB first. Opcode 10 is a read. On the rising edge that samples the last address bit, do_oe_o goes to 1 and do_o goes to 0. The next 16 rising edges present the word's bits 15 down to 0.
- R5: If the serial clock keeps running after a read word, the next address is output without a leading zero. Address 511 is followed by address 0.
- R6: Opcode 01 followed by 16 data bits writes that word to the addressed location. The write is committed when chip select falls.
- R7: If more than 16 data bits are sent, the last 16 received are the ones written.
- R8: Opcode 11 sets the addressed word to FFFFh when chip select falls.
- R9: With opcode 00, the top two address bits select a whole-array command, and the remaining seven bits are don't-care. The value 01 is followed by 16 data bits and writes that data to every word. The value 10 sets every word to FFFFh.
- R10: After a commit, the busy window lasts WRITE_CYCLES system clocks. While chip select is high during this window, do_o is driven 0. After the window ends, do_o is driven 1.
- R11: Serial clock and data-in are ignored during the busy window, so a complete command sent then has no effect.
- R12: While the ready level is being driven, a start bit makes do_oe_o go to 0.
- R13: If chip select falls before a frame is complete, or before 16 data bits have been received, nothing is written and no busy window starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that oversamples the serial pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock from the host |
| di_i | input | 1 | Serial data from the host |
| do_o | output | 1 | Serial data / status out |
| do_oe_o | output | 1 | Output enable for do_o; 0 means high impedance |

## Verification
Reads run over words with distinct bit patterns, and one read crosses the top of the array. This separates a wrong bit order, a missing leading zero, a repeated word, and a wrap to the wrong address. Writes are sent in three forms: preceded by dummy clocks, with an overlong data field, and cut short. These show whether the start bit is found correctly, whether the data register keeps its newest bits, and whether an incomplete frame is dropped. The busy window is polled both just before and just after its nominal end. An erase sent inside that window must leave the freshly written word intact, which proves the lockout.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_READ, ST_WDATA, ST_ARMED, ST_SKIP
  } mw_state_e;

  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  localparam logic [1:0] EXT_FILL  = 2'b01;
  localparam logic [1:0] EXT_CLEAR = 2'b10;
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain[s] <= '0;
      else if (s == 0) chain[s] <= d_i;
      else chain[s] <= chain[s-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/mw_mem.sv
module mw_mem #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 16,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              all_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] words [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) words[i] <= '1;
    end else if (we_i) begin
      if (all_i) begin
        for (int i = 0; i < DEPTH; i++) words[i] <= wdata_i;
      end else begin
        words[waddr_i] <= wdata_i;
      end
    end
  end

  assign rdata_o = words[raddr_i];

  p_word_stored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && !all_i |=> words[$past(waddr_i)] == $past(wdata_i));
  p_fill_reaches_top_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && all_i |=> words[DEPTH-1] == $past(wdata_i));
endmodule

// File: rtl/mw_wtimer.sv
module mw_wtimer #(
  parameter int CYCLES = 64,
  localparam int CNT_W = $clog2(CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt    <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !busy_o) begin
        busy_o <= 1'b1;
        cnt    <= CNT_W'(CYCLES - 1);
      end else if (busy_o) begin
        if (cnt == '0) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  p_count_down_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) && $past(cnt) != '0 |-> cnt == $past(cnt) - 1'b1);
  p_done_ends_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o));
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
  import mw_pkg::*;
#(
  parameter int ADDR_W       = 9,
  parameter int DATA_W       = 16,
  parameter int WRITE_CYCLES = 64,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic do_o,
  output logic do_oe_o
);
  localparam int CMD_BITS = 3 + ADDR_W;
  localparam int CMD_CW   = $clog2(CMD_BITS + 1);
  localparam int IDX_W    = $clog2(DATA_W);
  localparam int DCNT_W   = $clog2(DATA_W + 1);

  logic cs_s, sk_s, di_s, sk_prev, cs_prev;
  logic sk_rise, cs_fall, start_det, commit, busy, done;

  mw_state_e         st;
  logic [CMD_BITS-1:0] cmd_sr, nxt;
  logic [CMD_CW-1:0] cmd_cnt;
  logic [ADDR_W-1:0] tgt_addr, rd_addr, addr_n;
  logic [1:0]        op_n, ext_n;
  logic              wr_all, wr_erase;
  logic [DATA_W-1:0] data_sr, rdata;
  logic [DCNT_W-1:0] dcnt;
  logic [IDX_W-1:0]  rd_idx;
  logic              rd_bit, rd_active, rdy_show;

  mw_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni,
    .d_i({cs_i, sk_i, di_i}),
    .q_o({cs_s, sk_s, di_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sk_prev <= 1'b0;
      cs_prev <= 1'b0;
    end else begin
      sk_prev <= sk_s;
      cs_prev <= cs_s;
    end
  end

  assign sk_rise   = sk_s && !sk_prev;
  assign cs_fall   = cs_prev && !cs_s;
  assign start_det = cs_s && sk_rise && di_s && st == ST_IDLE && !busy;
  assign commit    = cs_fall && !busy &&
                     ((st == ST_WDATA && dcnt == DCNT_W'(DATA_W)) || st == ST_ARMED);

  assign nxt    = {cmd_sr[CMD_BITS-2:0], di_s};
  assign op_n   = nxt[CMD_BITS-1 -: 2];
  assign addr_n = nxt[ADDR_W-1:0];
  assign ext_n  = nxt[ADDR_W-1 -: 2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st        <= ST_IDLE;
      cmd_sr    <= '0;
      cmd_cnt   <= '0;
      tgt_addr  <= '0;
      wr_all    <= 1'b0;
      wr_erase  <= 1'b0;
      data_sr   <= '0;
      dcnt      <= '0;
      rd_addr   <= '0;
      rd_idx    <= '0;
      rd_bit    <= 1'b0;
      rd_active <= 1'b0;
      rdy_show  <= 1'b0;
    end else begin
      if (done) rdy_show <= 1'b1;
      if (start_det || commit) rdy_show <= 1'b0;

      if (busy || !cs_s) begin
        st        <= ST_IDLE;
        rd_active <= 1'b0;
      end else if (sk_rise) begin
        unique case (st)
          ST_IDLE: if (di_s) begin
            st      <= ST_CMD;
            cmd_cnt <= '0;
          end
          ST_CMD: begin
            cmd_sr  <= nxt;
            cmd_cnt <= cmd_cnt + 1'b1;
            if (cmd_cnt == CMD_CW'(CMD_BITS - 1)) begin
              tgt_addr <= addr_n;
              dcnt     <= '0;
              unique case (op_n)
                OP_READ: begin
                  st        <= ST_READ;
                  rd_addr   <= addr_n;
                  rd_idx    <= '0;
                  rd_bit    <= 1'b0;  // leading zero
                  rd_active <= 1'b1;
                end
                OP_WRITE: begin
                  st <= ST_WDATA; wr_all <= 1'b0; wr_erase <= 1'b0;
                end
                OP_ERASE: begin
                  st <= ST_ARMED; wr_all <= 1'b0; wr_erase <= 1'b1;
                end
                default: begin
                  if (ext_n == EXT_FILL) begin
                    st <= ST_WDATA; wr_all <= 1'b1; wr_erase <= 1'b0;
                  end else if (ext_n == EXT_CLEAR) begin
                    st <= ST_ARMED; wr_all <= 1'b1; wr_erase <= 1'b1;
                  end else begin
                    st <= ST_SKIP;
                  end
                end
              endcase
            end
          end
          ST_READ: begin
            rd_bit <= rdata[IDX_W'(DATA_W - 1) - rd_idx];
            if (rd_idx == IDX_W'(DATA_W - 1)) begin
              rd_idx  <= '0;
              rd_addr <= rd_addr + 1'b1;
            end else begin
              rd_idx <= rd_idx + 1'b1;
            end
          end
          ST_WDATA: begin
            data_sr <= {data_sr[DATA_W-2:0], di_s};
            if (dcnt != DCNT_W'(DATA_W)) dcnt <= dcnt + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  mw_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk_i, .rst_ni,
    .we_i   (commit),
    .all_i  (wr_all),
    .waddr_i(tgt_addr),
    .wdata_i(wr_erase ? {DATA_W{1'b1}} : data_sr),
    .raddr_i(rd_addr),
    .rdata_o(rdata)
  );

  mw_wtimer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk_i, .rst_ni,
    .start_i(commit),
    .busy_o (busy),
    .done_o (done)
  );

  assign do_oe_o = cs_s && (busy || rdy_show || rd_active);
  assign do_o    = do_oe_o && !busy && (rdy_show || rd_bit);

  p_standby_hiz_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_s |-> !do_oe_o);
  p_lead_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_active) |-> !rd_bit && $past(st) == ST_CMD);
  p_commit_on_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |-> $past(cs_s) && !cs_s);
  p_commit_starts_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> busy);
  p_lockout_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> st == ST_IDLE && !rd_active);
  p_start_hiz_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det && rdy_show |=> !rdy_show);
  p_abort_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall && st == ST_CMD |-> !commit);
endmodule

// File: tb/mw_eeprom_test.sv
`timescale 1ns/1ps
module mw_eeprom_test;
  localparam int WR   = 400;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic dout, doe;
  int unsigned cyc = 0;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mw_eeprom #(.WRITE_CYCLES(WR)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
    .do_o(dout), .do_oe_o(doe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sk_bit(input logic b);
    di = b;
    idle(HALF);
    sk = 1'b1;
    idle(HALF);
    sk = 1'b0;
  endtask

  task automatic send(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) sk_bit(v[i]);
  endtask

  task automatic cs_up(input int dummies);
    cs = 1'b1;
    idle(3);
    for (int i = 0; i < dummies; i++) sk_bit(1'b0);
  endtask

  task automatic cs_down();
    idle(HALF);
    cs = 1'b0;
    di = 1'b0;
    idle(2 * HALF);
  endtask

  task automatic header(input logic [1:0] op, input logic [8:0] a);
    sk_bit(1'b1);
    send({30'd0, op}, 2);
    sk_bit(1'b0);
    send({23'd0, a}, 9);
  endtask

  // read n words starting at a, compare with exp list
  task automatic read_chk(input string req, input logic [8:0] a, input int n,
                          input logic [15:0] e0, input logic [15:0] e1,
                          input logic [15:0] e2, input logic [15:0] e3);
    logic [15:0] exp [4];
    logic [15:0] got;
    exp[0] = e0; exp[1] = e1; exp[2] = e2; exp[3] = e3;
    cs_up(0);
    header(2'b10, a);
    idle(HALF);
    chk("R4 lead oe", {31'd0, doe}, 32'd1);
    chk("R4 lead zero", {31'd0, dout}, 32'd0);
    for (int w = 0; w < n; w++) begin
      got = '0;
      for (int b = 0; b < 16; b++) begin
        sk_bit(1'b0);
        idle(HALF);
        got = {got[14:0], dout};
      end
      chk(req, {16'd0, got}, {16'd0, exp[w]});
    end
    cs_down();
  endtask

  task automatic write_word(input logic [8:0] a, input logic [15:0] d, input int dummies);
    cs_up(dummies);
    header(2'b01, a);
    send({16'd0, d}, 16);
    cs_down();
    idle(WR + 20);
  endtask

  task automatic t_reset();
    chk("R2 reset oe", {31'd0, doe}, 32'd0);
    read_chk("R1 word0", 9'd0, 1, 16'hFFFF, 0, 0, 0);
    read_chk("R1 word511", 9'd511, 1, 16'hFFFF, 0, 0, 0);
  endtask

  task automatic t_standby();
    di = 1'b1;
    for (int i = 0; i < 30; i++) begin
      sk = ~sk;
      idle(HALF);
      chk("R2 standby oe", {31'd0, doe}, 32'd0);
    end
    sk = 1'b0; di = 1'b0;
    idle(WR + 20);
    read_chk("R2 no effect", 9'd3, 1, 16'hFFFF, 0, 0, 0);
  endtask

  task automatic t_write_read();
    write_word(9'd5, 16'hA5C3, 3);
    read_chk("R3 R6 dummy+write", 9'd5, 1, 16'hA5C3, 0, 0, 0);
  endtask

  task automatic t_seq_wrap();
    write_word(9'd510, 16'h1111, 0);
    write_word(9'd511, 16'h2C2C, 0);
    write_word(9'd0, 16'h3333, 0);
    read_chk("R5 seq wrap", 9'd510, 4, 16'h1111, 16'h2C2C, 16'h3333, 16'hFFFF);
  endtask

  task automatic t_overlong();
    cs_up(0);
    header(2'b01, 9'd7);
    send(32'hA, 4);
    send(32'h1234, 16);
    cs_down();
    idle(WR + 20);
    read_chk("R7 last16", 9'd7, 1, 16'h1234, 0, 0, 0);
  endtask

  task automatic t_erase();
    cs_up(0);
    header(2'b11, 9'd5);
    cs_down();
    idle(WR + 20);
    read_chk("R8 erase", 9'd5, 1, 16'hFFFF, 0, 0, 0);
    read_chk("R8 neighbour", 9'd7, 1, 16'h1234, 0, 0, 0);
  endtask

  task automatic t_all();
    cs_up(0);
    header(2'b00, 9'b01_0110101);
    send(32'h0F0F, 16);
    cs_down();
    idle(WR + 20);
    read_chk("R9 fill", 9'd0, 2, 16'h0F0F, 16'h0F0F, 0, 0);
    read_chk("R9 fill top", 9'd511, 1, 16'h0F0F, 0, 0, 0);
    cs_up(0);
    header(2'b00, 9'b10_1001010);
    cs_down();
    idle(WR + 20);
    read_chk("R9 clear", 9'd100, 2, 16'hFFFF, 16'hFFFF, 0, 0);
  endtask

  task automatic t_busy();
    int unsigned t0;
    cs_up(0);
    header(2'b01, 9'd9);
    send(32'hBEEF, 16);
    idle(HALF);
    cs = 1'b0;
    t0 = cyc;
    idle(4);
    cs = 1'b1;
    idle(6);
    chk("R10 busy oe", {31'd0, doe}, 32'd1);
    chk("R10 busy low", {31'd0, dout}, 32'd0);
    header(2'b11, 9'd9);   // erase during busy: must be ignored
    idle(HALF);
    cs = 1'b0;
    idle(4);
    cs = 1'b1;
    while (cyc < t0 + WR - 20) @(negedge clk);
    chk("R10 still busy", {30'd0, doe, dout}, 32'b10);
    while (cyc < t0 + WR + 20) @(negedge clk);
    chk("R10 ready", {30'd0, doe, dout}, 32'b11);
    sk_bit(1'b1);
    idle(HALF);
    chk("R12 start hiz", {31'd0, doe}, 32'd0);
    cs_down();
    read_chk("R11 lockout", 9'd9, 1, 16'hBEEF, 0, 0, 0);
  endtask

  task automatic t_abort();
    cs_up(0);
    header(2'b01, 9'd12);
    send(32'h5A, 8);
    cs_down();
    cs = 1'b1;
    idle(6);
    chk("R13 no busy", {31'd0, doe}, 32'd0);
    cs = 1'b0;
    idle(4);
    cs_up(0);
    sk_bit(1'b1);
    send(32'b11, 2);
    sk_bit(1'b0);
    send(32'd12, 5);
    cs_down();
    cs = 1'b1;
    idle(6);
    chk("R13 no busy hdr", {31'd0, doe}, 32'd0);
    cs = 1'b0;
    idle(4);
    read_chk("R13 kept", 9'd12, 1, 16'hFFFF, 0, 0, 0);
  endtask

  initial begin
    idle(5);
    rst_n = 1'b1;
    idle(5);
    t_reset();
    t_standby();
    t_write_read();
    t_seq_wrap();
    t_overlong();
    t_erase();
    t_all();
    t_busy();
    t_abort();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule